// File: doc/BRIEF.md
# Row-Buffered Serial EEPROM Write Path

This block sits behind the byte engine of a two-wire serial memory slave. After the engine has decoded a write command, it hands over the start address. Each received data byte follows with a strobe, and the end of the command arrives as a STOP or a repeated START event. The block gathers the bytes in a set of sixteen row slots. For each byte it returns an accept-or-reject decision. On STOP it copies the gathered bytes into its byte array. While that copy and the simulated programming time are in progress, it raises a busy flag and ignores every input.

The copy mode is taken from a mode input, which is sampled when the address is loaded. In row-wrap (page) mode, up to sixteen bytes are taken. Only the four low address bits advance, so extra bytes land back at the start of the same sixteen-byte row and replace what was gathered there. In linear (multibyte) mode, up to eight bytes are taken from any start address and the full address advances, so the run may cross into the next row. A crossing doubles the busy time. Each byte write is simply a command with one data byte. Locations that were not written keep their contents. A read port shows the array contents, and after reset every array byte is 0xFF.

The controller has four states. ST_IDLE waits for an address. ST_COLLECT gathers bytes. ST_COMMIT walks the slots and writes the valid ones into the array. ST_HOLD waits for the rest of the programming time. The transitions are:
- ST_IDLE to ST_COLLECT on an address load.
- ST_COLLECT to ST_COLLECT on a further address load, which reloads the address.
- ST_COLLECT to ST_IDLE on a repeated START, or on a STOP with no data byte.
- ST_COLLECT to ST_COMMIT on a STOP once at least one byte has been taken.
- ST_COMMIT to ST_HOLD after the last slot.
- ST_COMMIT or ST_HOLD to ST_IDLE when the timer runs out.

Top module: `ewp_write_path`

## Requirements
- R1: After reset, busy is 0, no acknowledge strobe is issued, and every array byte reads 0xFF.
- R2: One data byte followed by STOP writes exactly that location, in either mode. The other bytes of the row keep their contents.
- R3: In page mode (mode_multi = 0 at address load), every one of up to 16 or more bytes is accepted. The write address is {addr[10:4], (addr[3:0] + n) mod 16} for byte n, so a later byte replaces an earlier byte at the same slot.
- R4: In multibyte mode (mode_multi = 1 at address load), the first 8 bytes are accepted at addr + n, and this address may pass into the next row. Byte 9 and later bytes are rejected and are not written.
- R5: busy rises on the first clock edge that samples stop_evt with at least one accepted byte. It stays high for exactly WR_CYCLES cycles when all written bytes lie in one row.
- R6: A multibyte write whose bytes span two rows keeps busy high for 2*WR_CYCLES cycles.
- R7: While busy is high, data bytes are rejected. Address loads, STOP and repeated START have no effect: no second busy period follows, and the array is not written.
- R8: A repeated START after the address, or a STOP with no data byte, starts no write cycle and leaves the array unchanged.
- R9: Every byte_valid produces ack_stb exactly one cycle later. ack_ok is 1 when the byte was taken, and it is 0 for a byte that arrives with no address loaded.
- R10: The mode is latched at the address load. A change of mode_multi during the byte phase does not alter the addressing of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_multi | input | 1 | 1 = linear multibyte, 0 = row-wrap page; sampled at address load |
| addr_load | input | 1 | Start address strobe from the byte engine |
| addr_in | input | ADDR_W | Start byte address |
| byte_valid | input | 1 | Data byte strobe |
| byte_in | input | DATA_W | Data byte |
| stop_evt | input | 1 | STOP seen on the bus |
| restart_evt | input | 1 | Repeated START seen on the bus |
| ack_stb | output | 1 | Acknowledge decision valid, one cycle after byte_valid |
| ack_ok | output | 1 | 1 = byte accepted, 0 = reject |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |

## Verification
The acknowledge decision is registered once, so the bench expects ack_stb on the falling edge that follows the rising edge which sampled byte_valid. A scoreboard queue holds the expected decision for each byte and pops it exactly there. busy is expected high from the first falling edge after the STOP pulse, and the bench counts falling edges until it drops, comparing that count with WR_CYCLES or twice that. The array is only compared with the bench's model after busy has fallen, because the slot copy takes place during the busy window.

// File: rtl/ewp_pkg.sv
`timescale 1ns/1ps
package ewp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } ewp_state_e;
endpackage

// File: rtl/ewp_array.sv
`timescale 1ns/1ps
module ewp_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // erased state is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ewp_row_latch.sv
`timescale 1ns/1ps
module ewp_row_latch #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 wr,
    input  logic [ROW_W-1:0]                     wr_slot,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [(1<<ROW_W)-1:0]                valid,
    output logic [(1<<ROW_W)-1:0][ADDR_W-1:0]    slot_addr,
    output logic [(1<<ROW_W)-1:0][DATA_W-1:0]    slot_data
);
    localparam int NSLOT = 1 << ROW_W;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid[s]     <= 1'b0;
                slot_addr[s] <= '0;
                slot_data[s] <= '0;
            end else if (clr) begin
                valid[s]     <= 1'b0;
            end else if (wr && (wr_slot == ROW_W'(s))) begin
                valid[s]     <= 1'b1;
                slot_addr[s] <= wr_addr;
                slot_data[s] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ewp_busy_timer.sv
`timescale 1ns/1ps
module ewp_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt_q   <= load_val;
        end else if (running) begin
            if (cnt_q == '0) running <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign expire = running && (cnt_q == '0);

    AST_TIMER_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running); // R7
endmodule

// File: rtl/ewp_write_path.sv
`timescale 1ns/1ps
module ewp_write_path
    import ewp_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 4,
    parameter int MB_MAX    = 8,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_multi,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_evt,
    input  logic              restart_evt,
    output logic              ack_stb,
    output logic              ack_ok,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NSLOT  = 1 << ROW_W;
    localparam int BCNT_W = ROW_W + 1;
    localparam int CNT_W  = $clog2(2 * WR_CYCLES + 1);
    localparam int ROWA_W = ADDR_W - ROW_W;

    ewp_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic              multi_q;
    logic [ROW_W-1:0]  ptr_q;
    logic [BCNT_W-1:0] nbytes_q;
    logic              span_q;
    logic [ROW_W-1:0]  walk_q;

    logic              load_go, accept, commit_go, drop_go;
    logic [ROW_W-1:0]  acc_slot;
    logic [ADDR_W-1:0] acc_addr, mb_addr;
    logic              mb_cross;
    logic [CNT_W-1:0]  dur_val;
    logic              tmr_running, tmr_expire;

    logic [NSLOT-1:0]               slot_valid;
    logic [NSLOT-1:0][ADDR_W-1:0]   slot_addr;
    logic [NSLOT-1:0][DATA_W-1:0]   slot_data;
    logic                           mem_we;

    // event decode, only while not busy
    always_comb begin
        load_go   = addr_load && !restart_evt && !stop_evt &&
                    ((state_q == ST_IDLE) || (state_q == ST_COLLECT));
        drop_go   = (state_q == ST_COLLECT) &&
                    (restart_evt || (stop_evt && (nbytes_q == '0)));
        commit_go = (state_q == ST_COLLECT) && stop_evt && !restart_evt &&
                    (nbytes_q != '0);
        accept    = (state_q == ST_COLLECT) && byte_valid && !addr_load &&
                    !stop_evt && !restart_evt &&
                    (!multi_q || (nbytes_q < BCNT_W'(MB_MAX)));
    end

    // slot and address selection per mode
    always_comb begin
        mb_addr  = base_q + ADDR_W'(nbytes_q);
        mb_cross = (mb_addr[ADDR_W-1:ROW_W] != base_q[ADDR_W-1:ROW_W]);
        if (multi_q) begin
            acc_slot = nbytes_q[ROW_W-1:0];
            acc_addr = mb_addr;
        end else begin
            acc_slot = ptr_q;
            acc_addr = {base_q[ADDR_W-1:ROW_W], ptr_q};
        end
        dur_val = (multi_q && span_q) ? CNT_W'(2 * WR_CYCLES - 1)
                                      : CNT_W'(WR_CYCLES - 1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_go) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (commit_go)    state_d = ST_COMMIT;
                else if (drop_go) state_d = ST_IDLE;
            end
            ST_COMMIT: begin
                if (tmr_expire)                        state_d = ST_IDLE;
                else if (walk_q == ROW_W'(NSLOT - 1))  state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command context and slot walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            multi_q  <= 1'b0;
            ptr_q    <= '0;
            nbytes_q <= '0;
            span_q   <= 1'b0;
            walk_q   <= '0;
        end else begin
            if (load_go) begin
                base_q   <= addr_in;
                multi_q  <= mode_multi;
                ptr_q    <= addr_in[ROW_W-1:0];
                nbytes_q <= '0;
                span_q   <= 1'b0;
            end else if (accept) begin
                ptr_q <= ptr_q + 1'b1;
                if (nbytes_q != BCNT_W'(NSLOT)) nbytes_q <= nbytes_q + 1'b1;
                if (multi_q && mb_cross) span_q <= 1'b1;
            end
            if (commit_go)                walk_q <= '0;
            else if (state_q == ST_COMMIT) walk_q <= walk_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_stb <= 1'b0;
            ack_ok  <= 1'b0;
        end else begin
            ack_stb <= byte_valid;
            ack_ok  <= accept;
        end
    end

    assign busy   = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
    assign mem_we = (state_q == ST_COMMIT) && slot_valid[walk_q];

    ewp_row_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (load_go),
        .wr        (accept),
        .wr_slot   (acc_slot),
        .wr_addr   (acc_addr),
        .wr_data   (byte_in),
        .valid     (slot_valid),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    ewp_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit_go),
        .load_val (dur_val),
        .running  (tmr_running),
        .expire   (tmr_expire)
    );

    ewp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (slot_addr[walk_q]),
        .wdata (slot_data[walk_q]),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    logic [ROWA_W-1:0] unused_row;
    assign unused_row = '0;

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_valid) |=> (ack_stb && !ack_ok)); // R7
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt)); // R5
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> tmr_running); // R5
    AST_RESTART_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COLLECT) && restart_evt) |=> !busy); // R8
    AST_MB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        multi_q |-> ($countones(slot_valid) <= MB_MAX)); // R4
    AST_NO_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && byte_valid) |=> !ack_ok); // R9
endmodule

// File: tb/ewp_write_path_bench.sv
`timescale 1ns/1ps
module ewp_write_path_bench;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int WR = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_multi = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_in = '0;
    logic          stop_evt = 1'b0;
    logic          restart_evt = 1'b0;
    logic          ack_stb, ack_ok, busy;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit exp_ack [$];
    logic [DW-1:0] model [1 << AW];

    always #10 clk = ~clk;

    ewp_write_path #(.ADDR_W(AW), .DATA_W(DW), .ROW_W(4), .MB_MAX(8), .WR_CYCLES(WR))
    u_ewp_write_path (
        .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .addr_load(addr_load),
        .addr_in(addr_in), .byte_valid(byte_valid), .byte_in(byte_in),
        .stop_evt(stop_evt), .restart_evt(restart_evt), .ack_stb(ack_stb),
        .ack_ok(ack_ok), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected decision per strobe (R9)
    always @(negedge clk) begin
        if (rst_n && ack_stb) begin
            if (exp_ack.size() == 0) begin
                chk(0, "R9", "unexpected ack strobe", 1, 0);
            end else begin
                automatic bit e = exp_ack.pop_front();
                chk(ack_ok == e, "R9", "ack decision", int'(ack_ok), int'(e));
            end
        end
    end

    task automatic load(input logic [AW-1:0] a, input bit m);
        @(negedge clk); addr_load = 1'b1; addr_in = a; mode_multi = m;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] d, input bit ok);
        exp_ack.push_back(ok);
        @(negedge clk); byte_valid = 1'b1; byte_in = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic stop_and_time(input int exp_len, input string req);
        int len;
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        if (exp_len > 0) chk(busy == 1'b1, req, "busy on edge after STOP", int'(busy), 1);
        len = 0;
        while (busy && len < 1000) begin len++; @(negedge clk); end
        chk(len == exp_len, req, "busy length", len, exp_len);
    endtask

    task automatic check_mem(input string req);
        int first_bad = -1;
        logic [DW-1:0] got = '0;
        for (int a = 0; a < (1 << AW); a++) begin
            rd_addr = AW'(a); #1;
            if (rd_data !== model[a] && first_bad < 0) begin first_bad = a; got = rd_data; end
        end
        if (first_bad < 0) chk(1, req, "array", 0, 0);
        else chk(0, req, $sformatf("array @%0h", first_bad), int'(got), int'(model[first_bad]));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "watchdog", "run did not end", 0, 1);
        finish_run();
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(ack_stb == 1'b0, "R1", "ack_stb after reset", int'(ack_stb), 0);
        check_mem("R1");

        // R2 byte write, page mode and multibyte mode
        load(11'h123, 1'b0); send(8'hA5, 1); model[11'h123] = 8'hA5;
        stop_and_time(WR, "R5");
        load(11'h200, 1'b1); send(8'h3C, 1); model[11'h200] = 8'h3C;
        stop_and_time(WR, "R2");
        check_mem("R2");

        // R3 page wrap within row
        load(11'h34C, 1'b0);
        for (int i = 0; i < 5; i++) begin
            send(DW'(8'h10 + i), 1);
            model[11'h340 | ((12 + i) & 15)] = DW'(8'h10 + i);
        end
        stop_and_time(WR, "R3");
        load(11'h400, 1'b0);
        for (int i = 0; i < 18; i++) begin
            send(DW'(8'h40 + i), 1);
            model[11'h400 | (i & 15)] = DW'(8'h40 + i);
        end
        stop_and_time(WR, "R3");
        check_mem("R3");

        // R4 multibyte aligned, single row
        load(11'h100, 1'b1);
        for (int i = 0; i < 8; i++) begin
            send(DW'(8'h80 + i), 1);
            model[11'h100 + i] = DW'(8'h80 + i);
        end
        stop_and_time(WR, "R4");
        // R4 and R6: cap of 8 and row crossing
        load(11'h1FC, 1'b1);
        for (int i = 0; i < 10; i++) begin
            if (i < 8) begin
                send(DW'(8'hC0 + i), 1);
                model[11'h1FC + i] = DW'(8'hC0 + i);
            end else begin
                send(DW'(8'hC0 + i), 0);
            end
        end
        stop_and_time(2 * WR, "R6");
        check_mem("R4");

        // R7 inputs ignored while busy
        begin
            int len;
            load(11'h600, 1'b0); send(8'h11, 1); model[11'h600] = 8'h11;
            @(negedge clk); stop_evt = 1'b1;
            @(negedge clk); stop_evt = 1'b0;
            len = 1;
            send(8'h99, 0); len += 2;
            @(negedge clk); addr_load = 1'b1; addr_in = 11'h700; len++;
            @(negedge clk); addr_load = 1'b0; stop_evt = 1'b1; len++;
            @(negedge clk); stop_evt = 1'b0; restart_evt = 1'b1; len++;
            @(negedge clk); restart_evt = 1'b0; len++;
            while (busy && len < 1000) begin len++; @(negedge clk); end
            chk(len - 1 == WR, "R7", "busy length with ignored inputs", len - 1, WR);
            repeat (5) @(negedge clk);
            chk(busy == 1'b0, "R7", "no second cycle", int'(busy), 0);
            send(8'h55, 0);
            check_mem("R7");
        end

        // R8 dummy write via repeated START, and STOP with no data
        load(11'h080, 1'b0);
        @(negedge clk); restart_evt = 1'b1;
        @(negedge clk); restart_evt = 1'b0;
        send(8'h77, 0);
        stop_and_time(0, "R8");
        load(11'h090, 1'b0);
        stop_and_time(0, "R8");
        check_mem("R8");

        // R10 mode latched at address load
        load(11'h50E, 1'b0);
        mode_multi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            send(DW'(8'hE0 + i), 1);
            model[11'h500 | ((14 + i) & 15)] = DW'(8'hE0 + i);
        end
        stop_and_time(WR, "R10");
        check_mem("R10");

        @(negedge clk);
        chk(exp_ack.size() == 0, "R9", "pending ack decisions", exp_ack.size(), 0);
        finish_run();
    end
endmodule